// File: doc/BRIEF.md
# Atomic Prefix-Sum Accumulator

This block holds one shared 32-bit counter that many requesters update at once. A requester presents an increment on its port. The block adds that increment to the counter as a single indivisible step. One cycle later it hands back the value the counter held before the add. When the increment is one, the block acts as a fetch-and-increment, and every caller receives a different ticket. When the increment is larger, the caller reserves a contiguous run of slots, and the returned value is the base of that run. This lets threads pack variable-length output into a shared buffer without collisions.

All ports that request in the same cycle are served together, in ascending port order. Port k sees the starting value plus the increments of every lower-numbered port that is also requesting. The counter then advances by the total of all increments presented that cycle.

Requests are served only while the parallel-mode input is high. A separate host port can load or read the counter directly, but only in serial mode. Any host access attempted during parallel mode is refused with an error flag.

Top module: `psum_accum`

## Requirements
- R1: After reset the counter is 0, no response is valid, and both host_ack and host_err are low.
- R2: While par_mode is high, a request on one port returns the counter value from before the add, one cycle after the request. The counter advances by the increment.
- R3: Requests presented in the same cycle are served in ascending port order. Port k receives the base value plus the sum of the increments of all lower-numbered requesting ports. The counter advances by the total of all those increments.
- R4: The increment on a port whose req_valid bit is low has no effect on other ports' returned values or on the counter.
- R5: rsp_valid bit k rises exactly one cycle after an accepted request on port k. Field k of rsp_tag (TW bits wide, at bit offset k*TW) carries the value k.
- R6: The counter wraps modulo 2^32.
- R7: An increment of zero returns the current value and leaves the counter unchanged.
- R8: In serial mode (par_mode low), host_wr loads host_wdata into the counter. host_ack is high the next cycle.
- R9: In serial mode, host_rd returns the counter value on host_rdata the next cycle, with host_ack high. If host_wr is asserted in the same cycle, the value returned is the one from before the load.
- R10: A host read or load attempted while par_mode is high raises host_err the next cycle, with host_ack low, and leaves the counter unchanged.
- R11: Requests presented while par_mode is low are ignored: no response is produced and the counter is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_mode | input | 1 | High while the array runs in parallel mode |
| req_valid | input | N | One request bit per port |
| req_inc | input | N*W | Increment of each port, port k at bits k*W |
| rsp_valid | output | N | Response valid per port |
| rsp_old | output | N*W | Pre-add value returned to each port |
| rsp_tag | output | N*TW | Port index returned with each response |
| host_wr | input | 1 | Host load strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | W | Host load value |
| host_rdata | output | W | Host read value |
| host_ack | output | 1 | Host access completed |
| host_err | output | 1 | Host access refused in parallel mode |

## Verification
The bench covers several same-cycle request patterns where serialization order matters:
- All ports requesting together.
- Sparse requesters that leave gaps between them.
- Idle ports that carry large, non-zero increments on req_inc.

A design that served ports in the wrong order, or summed in increments from idle ports, would return shifted tickets. The bench also targets:
- Wrap-around at 2^32. A saturating or wider adder would show there.
- Zero increments, which must return the current value without moving the counter.
- Host access during parallel mode, which a design lacking the lockout would apply silently.
- Requests made in serial mode, which must leave the counter untouched. The bench confirms this by reading the counter back through the host port.

// File: rtl/psum_accum.sv
module psum_accum #(
  parameter int N = 4,
  parameter int W = 32,
  localparam int TW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_mode,
  input  logic [N-1:0]   req_valid,
  input  logic [N*W-1:0] req_inc,
  output logic [N-1:0]   rsp_valid,
  output logic [N*W-1:0] rsp_old,
  output logic [N*TW-1:0] rsp_tag,
  input  logic           host_wr,
  input  logic           host_rd,
  input  logic [W-1:0]   host_wdata,
  output logic [W-1:0]   host_rdata,
  output logic           host_ack,
  output logic           host_err
);

  logic [W-1:0] acc;
  logic [N-1:0] fire;
  logic [W-1:0] pre [N+1];
  logic         host_req;

  assign fire     = req_valid & {N{par_mode}};
  assign host_req = host_wr | host_rd;

  always_comb begin
    pre[0] = acc;
    for (int k = 0; k < N; k++)
      pre[k+1] = pre[k] + (fire[k] ? req_inc[k*W +: W] : '0);
  end

  for (genvar k = 0; k < N; k++) begin : g_tag
    assign rsp_tag[k*TW +: TW] = TW'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc        <= '0;
      rsp_valid  <= '0;
      rsp_old    <= '0;
      host_rdata <= '0;
      host_ack   <= 1'b0;
      host_err   <= 1'b0;
    end else begin
      rsp_valid <= fire;
      for (int k = 0; k < N; k++)
        if (fire[k]) rsp_old[k*W +: W] <= pre[k];
      host_err <= par_mode & host_req;
      host_ack <= ~par_mode & host_req;
      if (!par_mode && host_rd) host_rdata <= acc;
      if (par_mode)      acc <= pre[N];
      else if (host_wr)  acc <= host_wdata;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_chk
    a_r5_rsp_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (par_mode && req_valid[k]) |=> rsp_valid[k]);
    a_r11_serial_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      (!par_mode) |=> !rsp_valid[k]);
  end

  a_r8_host_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && host_wr) |=> (acc == $past(host_wdata)) && host_ack);

  a_r10_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode && host_req && req_valid == '0) |=> $stable(acc) && host_err && !host_ack);

  a_r11_serial_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && !host_wr) |=> $stable(acc));

  a_r9_ack_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_ack, host_err}));

endmodule

// File: tb/tb_psum_accum.sv
module tb_psum_accum;
  localparam int N = 4;
  localparam int W = 32;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic par_mode = 1'b0;
  logic [N-1:0] req_valid = '0;
  logic [N*W-1:0] req_inc = '0;
  logic [N-1:0] rsp_valid;
  logic [N*W-1:0] rsp_old;
  logic [N*TW-1:0] rsp_tag;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [W-1:0] host_wdata = '0;
  logic [W-1:0] host_rdata;
  logic host_ack, host_err;

  int checks = 0, errors = 0;
  logic [W-1:0] model = '0;
  bit done = 0;

  always #2 clk = ~clk;

  psum_accum #(.N(N), .W(W)) dut (.*);

  // vector: valid[131:128], inc3, inc2, inc1, inc0
  localparam logic [N+N*W-1:0] VEC [5] = '{
    {4'b0001, 32'd0, 32'd0, 32'd0, 32'd5},
    {4'b1111, 32'd4, 32'd3, 32'd2, 32'd1},
    {4'b1010, 32'd9, 32'd50, 32'd7, 32'd50},
    {4'b0100, 32'd0, 32'd0, 32'd0, 32'd0},
    {4'b0110, 32'd0, 32'd3, 32'd0, 32'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] v, input logic [N*W-1:0] inc, input string req);
    logic [W-1:0] base;
    base = model;
    req_valid = v; req_inc = inc;
    @(negedge clk);
    req_valid = '0; req_inc = '0;
    for (int k = 0; k < N; k++) begin
      if (v[k]) begin
        chk(rsp_valid[k] == 1'b1, "R5", W'(rsp_valid[k]), 1);
        chk(rsp_tag[k*TW +: TW] == TW'(k), "R5", W'(rsp_tag[k*TW +: TW]), k);
        chk(rsp_old[k*W +: W] == base, req, rsp_old[k*W +: W], base);
        base = base + inc[k*W +: W];
      end else
        chk(rsp_valid[k] == 1'b0, "R4", W'(rsp_valid[k]), 0);
    end
    model = base;
  endtask

  task automatic host(input bit wr, input bit rd, input logic [W-1:0] d);
    host_wr = wr; host_rd = rd; host_wdata = d;
    @(negedge clk);
    host_wr = 0; host_rd = 0;
  endtask

  task automatic read_chk(input logic [W-1:0] exp, input string req);
    par_mode = 0;
    host(0, 1, '0);
    chk(host_ack && !host_err, req, W'(host_ack), 1);
    chk(host_rdata == exp, req, host_rdata, exp);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(rsp_valid == '0, "R1", W'(rsp_valid), 0);
    chk(!host_ack && !host_err, "R1", W'({host_ack, host_err}), 0);
    read_chk(32'd0, "R1");

    host(1, 0, 32'd100);
    chk(host_ack && !host_err, "R8", W'(host_ack), 1);
    model = 32'd100;
    read_chk(32'd100, "R8");

    par_mode = 1;
    for (int i = 0; i < 5; i++)
      step(VEC[i][N*W +: N], VEC[i][N*W-1:0], (i == 2) ? "R4" : (i >= 3) ? "R7" : (i == 1) ? "R3" : "R2");
    read_chk(model, "R3");
    chk(model == 32'd134, "R3", model, 32'd134);

    host(1, 0, 32'hFFFF_FFFE);
    model = 32'hFFFF_FFFE;
    par_mode = 1;
    step(4'b0001, {96'd0, 32'd3}, "R6");
    step(4'b0001, 128'd0, "R6");
    chk(model == 32'd1, "R6", model, 1);

    host(1, 0, 32'd555);
    chk(host_err && !host_ack, "R10", W'({host_ack, host_err}), 1);
    host(0, 1, '0);
    chk(host_err && !host_ack, "R10", W'({host_ack, host_err}), 1);
    read_chk(32'd1, "R10");

    host(1, 1, 32'd77);
    chk(host_rdata == 32'd1, "R9", host_rdata, 1);
    read_chk(32'd77, "R9");

    par_mode = 0;
    req_valid = 4'b1111; req_inc = {4{32'd1}};
    @(negedge clk);
    req_valid = '0; req_inc = '0;
    chk(rsp_valid == '0, "R11", W'(rsp_valid), 0);
    read_chk(32'd77, "R11");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule